// File: doc/BRIEF.md
# Clock-Synchronous Serial Transfer Unit

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a serial output and a serial input. Software selects the clock source, the divide ratio and the bit order in a mode register, then writes a byte into the data register. That register becomes the shifter. On every shift clock one bit leaves on the serial output and one bit enters from the serial input. After the eighth clock, the register holds the received byte and an interrupt request goes high.

The shift clock comes from one of two places. The first is an internal divider, fed by a main or a sub oscillator tick and divided by 8, 16, 32 or 64. The second is an external clock pin, which passes through a synchronizer into the core clock domain. In internal mode the block drives the clock pin and holds it high when idle.

Top module: `sio_unit`

## Requirements
- R1: After reset, irq and busy are 0, sclk_out is 1 and sclk_oe is 1. All mode fields are 0, which selects the internal clock, divide by 8 and LSB first.
- R2: A data_wr pulse loads wdata into the shifter, which reads back on shift_q. busy is 1 from the next cycle.
- R3: A transfer moves exactly 8 bits in both directions at once. At its end, shift_q holds the 8 bits received on sdi.
- R4: Mode field msb_first is written from wdata bit 5. With 0, bit 0 is sent first and the first received bit lands in bit 0. With 1, bit 7 is sent first and the first received bit lands in bit 7.
- R5: The ratio field is written from wdata bits 1:0. The values 00, 01, 10 and 11 give a shift-clock period of 8, 16, 32 or 64 oscillator ticks. sclk_out stays low for half the period.
- R6: src_sel = 0 counts main_tick and src_sel = 1 counts sub_tick.
- R7: The ext_clk field is written from wdata bit 2. With 1, sclk_out is not used and sclk_oe is 0. The shifter is then paced by sclk_in edges after a two-stage synchronizer.
- R8: In internal mode, sclk_out is high whenever the unit is idle. sdo changes only after a falling shift-clock edge, and sdi is sampled on the rising edge.
- R9: In the cycle busy falls at the end of a transfer, irq rises. irq then holds until irq_clr is pulsed.
- R10: A data_wr during a transfer reloads the shifter and restarts the bit count. The clock restarts from its high phase.
- R11: While idle, edges on sclk_in change neither shift_q nor irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | Main oscillator tick, one clk cycle wide |
| sub_tick | input | 1 | Sub oscillator tick, one clk cycle wide |
| src_sel | input | 1 | Divider source: 0 main, 1 sub |
| mode_wr | input | 1 | Write strobe for the mode register |
| data_wr | input | 1 | Write strobe for the data register; starts a transfer |
| wdata | input | 8 | Write data for both registers |
| shift_q | output | 8 | Shifter contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete interrupt request |
| irq_clr | input | 1 | Clears irq |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock |
| sclk_oe | output | 1 | Drive enable for sclk_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the unit with its defaults: an 8-bit shifter, a minimum divide of 8 and two synchronizer stages. main_tick is held high every cycle, so the divide ratios become clock half-periods of 4 to 32 cycles. All four ratios can then be measured exactly within a short run. sub_tick fires every fourth cycle, so the same half-period scales by four and the two sources can be told apart. The external clock is driven with 6-cycle half periods, which leaves room for the synchronizer delay before the bench samples sdo.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W      = 8;
  localparam int RATIO_W     = 2;
  localparam int DIV_LOG_MIN = 3;
  localparam int SYNC_STAGES = 2;

  localparam int MODE_RATIO_LSB = 0;
  localparam int MODE_EXT_BIT   = 2;
  localparam int MODE_ORDER_BIT = 5;

  typedef struct packed {
    logic               msb_first;
    logic               ext_clk;
    logic [RATIO_W-1:0] ratio;
  } mode_t;
endpackage

// File: rtl/sio_clkdiv.sv
module sio_clkdiv #(
  parameter int DIV_LOG_MIN = 3,
  parameter int RATIO_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               main_tick,
  input  logic               sub_tick,
  input  logic               src_sel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               run,
  input  logic               restart,
  output logic               sclk_o,
  output logic               fall_evt,
  output logic               rise_evt
);
  localparam int CNT_W = DIV_LOG_MIN + (1 << RATIO_W);

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             sclk_q, sclk_d;
  logic             tick, hit;

  assign tick    = src_sel ? sub_tick : main_tick;
  assign half_m1 = (CNT_W'(1) << (CNT_W'(DIV_LOG_MIN - 1) + CNT_W'(ratio))) - CNT_W'(1);
  assign hit     = run && tick && (cnt_q == half_m1);

  assign fall_evt = hit && sclk_q;
  assign rise_evt = hit && !sclk_q;
  assign sclk_o   = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run || restart) begin
      cnt_d  = '0;
      sclk_d = 1'b1;
    end else if (tick) begin
      if (hit) begin
        cnt_d  = '0;
        sclk_d = !sclk_q;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end
endmodule

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] && !prev_q;
  assign fall_o = !chain_q[STAGES-1] && prev_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         msb_first,
  input  logic         fall_evt,
  input  logic         rise_evt,
  input  logic         sdi,
  output logic [W-1:0] sr_o,
  output logic         sdo,
  output logic         busy_o,
  output logic         done
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          sdo_q, sdo_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    sdo_d  = sdo_q;
    done   = 1'b0;
    if (load) begin
      sr_d   = load_data;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (fall_evt) begin
        sdo_d = msb_first ? sr_q[W-1] : sr_q[0];
      end
      if (rise_evt) begin
        sr_d = msb_first ? {sr_q[W-2:0], sdi} : {sdi, sr_q[W-1:1]};
        if (cnt_q == CW'(W - 1)) begin
          done   = 1'b1;
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      sdo_q  <= sdo_d;
    end
  end

  assign sr_o   = sr_q;
  assign sdo    = sdo_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/sio_unit.sv
module sio_unit
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_tick,
  input  logic              sub_tick,
  input  logic              src_sel,
  input  logic              mode_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] shift_q,
  output logic              busy,
  output logic              irq,
  input  logic              irq_clr,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo
);
  logic [1:0] rsync_q;
  logic       rst_s_n;
  mode_t      mode_q, mode_d;
  logic       irq_q, irq_d;
  logic       int_fall, int_rise, ext_fall, ext_rise;
  logic       fall_evt, rise_evt, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) begin
      mode_d.ratio     = wdata[MODE_RATIO_LSB +: RATIO_W];
      mode_d.ext_clk   = wdata[MODE_EXT_BIT];
      mode_d.msb_first = wdata[MODE_ORDER_BIT];
    end
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (done)    irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      irq_q  <= irq_d;
    end
  end

  sio_clkdiv #(.DIV_LOG_MIN(DIV_LOG_MIN), .RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_s_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .src_sel(src_sel), .ratio(mode_q.ratio), .run(busy && !mode_q.ext_clk),
    .restart(data_wr), .sclk_o(sclk_out), .fall_evt(int_fall), .rise_evt(int_rise)
  );

  sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .async_i(sclk_in), .rise_o(ext_rise), .fall_o(ext_fall)
  );

  assign fall_evt = mode_q.ext_clk ? ext_fall : int_fall;
  assign rise_evt = mode_q.ext_clk ? ext_rise : int_rise;

  sio_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .load(data_wr), .load_data(wdata),
    .msb_first(mode_q.msb_first), .fall_evt(fall_evt), .rise_evt(rise_evt),
    .sdi(sdi), .sr_o(shift_q), .sdo(sdo), .busy_o(busy), .done(done)
  );

  assign irq     = irq_q;
  assign sclk_oe = !mode_q.ext_clk;
endmodule

// File: rtl/sio_unit_chk.sv
module sio_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic data_wr,
  input logic busy,
  input logic irq,
  input logic irq_clr,
  input logic ext_mode,
  input logic sclk_out,
  input logic sdo
);
  a_r2_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> busy);
  a_r9_end_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !busy) |-> sclk_out);
  a_r8_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $rose(sclk_out)) |-> $stable(sdo));
endmodule

bind sio_unit sio_unit_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .data_wr(data_wr), .busy(busy), .irq(irq),
  .irq_clr(irq_clr), .ext_mode(mode_q.ext_clk), .sclk_out(sclk_out), .sdo(sdo)
);

// File: tb/sio_unit_bench.sv
module sio_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_tick = 1'b1;
  logic       sub_tick = 1'b0;
  logic       src_sel = 1'b0;
  logic       mode_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] shift_q;
  logic       busy, irq, sclk_out, sclk_oe, sdo;
  logic       irq_clr = 1'b0;
  logic       sclk_in = 1'b1;
  logic       sdi = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  logic       irq_prev = 1'b0;

  always #10 clk = !clk;

  sio_unit u_sio_unit (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .src_sel(src_sel), .mode_wr(mode_wr), .data_wr(data_wr), .wdata(wdata),
    .shift_q(shift_q), .busy(busy), .irq(irq), .irq_clr(irq_clr),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo)
  );

  always @(negedge clk) begin
    cyc++;
    sub_tick <= (cyc % 4 == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops the expected received byte on each irq rise
  always @(negedge clk) begin
    if (irq && !irq_prev) begin
      if (exp_q.size() == 0) check("R9 unexpected irq", 32'd1, 32'd0);
      else check("R3 received byte", 32'(shift_q), 32'(exp_q.pop_front()));
      check("R9 busy low with irq", 32'(busy), 32'd0);
    end
    irq_prev <= irq;
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [7:0] m);
    mode_wr = 1'b1; wdata = m; wcyc(1); mode_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] d);
    data_wr = 1'b1; wdata = d; wcyc(1); data_wr = 1'b0;
  endtask

  function automatic logic pick(input logic [7:0] v, input int i, input logic msb);
    return msb ? v[7-i] : v[i];
  endfunction

  task automatic clear_irq();
    wcyc(3);
    check("R9 irq held", 32'(irq), 32'd1);
    irq_clr = 1'b1; wcyc(1); irq_clr = 1'b0;
    check("R9 irq cleared", 32'(irq), 32'd0);
  endtask

  // internal clock: bench acts as the peer device
  task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rx, input logic msb,
                          input int half, input string req);
    int lowc;
    exp_q.push_back(rx);
    for (int i = 0; i < 8; i++) begin
      while (sclk_out !== 1'b0) @(negedge clk);
      sdi = pick(rx, i, msb);
      lowc = 0;
      while (sclk_out === 1'b0) begin lowc++; @(negedge clk); end
      if (i == 0) check({req, " low width"}, 32'(lowc), 32'(half));
      check({req, " sdo bit"}, 32'(sdo), 32'(pick(tx, i, msb)));
    end
    wcyc(1);
    check("R8 idle high", 32'(sclk_out), 32'd1);
    clear_irq();
  endtask

  task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rx, input logic msb);
    exp_q.push_back(rx);
    check("R7 sclk_oe low", 32'(sclk_oe), 32'd0);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0; sdi = pick(rx, i, msb);
      wcyc(6);
      check("R7 ext sdo bit", 32'(sdo), 32'(pick(tx, i, msb)));
      sclk_in = 1'b1;
      wcyc(6);
    end
    clear_irq();
  endtask

  initial begin
    wcyc(5); rst_n = 1'b1; wcyc(4);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 sclk_out", 32'(sclk_out), 32'd1);
    check("R1 sclk_oe", 32'(sclk_oe), 32'd1);

    // R2 load and start
    wr_data(8'hA5);
    check("R2 busy", 32'(busy), 32'd1);
    check("R2 loaded", 32'(shift_q), 32'hA5);
    xfer_int(8'hA5, 8'h3C, 1'b0, 4, "R5 div8 R4 lsb");

    wr_mode(8'h21); wr_data(8'h96);
    xfer_int(8'h96, 8'hC3, 1'b1, 8, "R5 div16 R4 msb");
    wr_mode(8'h02); wr_data(8'h0F);
    xfer_int(8'h0F, 8'hF1, 1'b0, 16, "R5 div32");
    wr_mode(8'h03); wr_data(8'h81);
    xfer_int(8'h81, 8'h7E, 1'b0, 32, "R5 div64");

    // R6 sub oscillator
    src_sel = 1'b1; wr_mode(8'h00); wr_data(8'h5A);
    xfer_int(8'h5A, 8'h24, 1'b0, 16, "R6 sub source");
    src_sel = 1'b0;

    // R10 restart mid transfer
    wr_data(8'hFF); wcyc(20);
    check("R10 busy mid", 32'(busy), 32'd1);
    wr_data(8'h6D);
    check("R10 reloaded", 32'(shift_q), 32'h6D);
    xfer_int(8'h6D, 8'hB2, 1'b0, 4, "R10 restart");

    // R7 external clock, both orders
    wr_mode(8'h04); wr_data(8'hC5);
    xfer_ext(8'hC5, 8'h19, 1'b0);
    wr_mode(8'h24); wr_data(8'h3A);
    xfer_ext(8'h3A, 8'hE7, 1'b1);

    // R11 idle external edges ignored
    for (int i = 0; i < 4; i++) begin
      sclk_in = 1'b0; sdi = 1'b1; wcyc(5); sclk_in = 1'b1; wcyc(5);
    end
    check("R11 shift_q kept", 32'(shift_q), 32'hE7);
    check("R11 no irq", 32'(irq), 32'd0);
    check("R11 not busy", 32'(busy), 32'd0);
    check("R3 queue empty", 32'(exp_q.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wcyc(150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule